// File: doc/BRIEF.md
# Burst-Filled Three-Lane Output Buffer

This block sits between a transform engine and the output stream. The engine writes one entry per clock while a transform result comes out. Each entry holds three IQ samples, one per lane. The engine cannot be stalled, so the buffer never pushes back on it. On the read side, a downstream ready signal releases the entries, so a finished result waits in storage instead of leaving the moment the engine is done.

Each entry carries the per-lane length of its block, which is N/3 for a transform of N points. The read side uses the length stored with the entry at the head to work out where each block starts and ends, and drives start-of-packet and end-of-packet from that. Consecutive blocks may have different sizes.

Storage depth is a parameter. The system must size it for the longest burst that can pile up, because a write that arrives while the buffer is full is lost. Any such loss is recorded in a sticky overflow flag, which is meant for debug.

Top module: `burst_outbuf`

## Requirements
- R1: While reset is asserted and after it is released, `outValid`, `outSop`, `outEop` and `overflow` are all 0.
- R2: The read side is first-word-fall-through. A write accepted at a clock edge makes `outValid` high after that edge, with the oldest stored entry already on `outSamples`. `outValid` is high exactly when at least one entry is stored.
- R3: A write with `inValid` high while DEPTH entries are stored is dropped, and `overflow` is set on the next edge. `overflow` stays 1 until reset, and the entries already stored are unchanged.
- R4: Entries leave in the order they were written. An entry leaves only on an edge where `outValid` and `outReady` are both high. While `outReady` is low, `outSamples`, `outSop` and `outEop` hold their values.
- R5: Lane k of an entry sits in bits [k*SAMPLE_W +: SAMPLE_W] of `inSamples`, and it comes out in the same bit positions of `outSamples`. `outSop` is high on the first entry of a block and `outEop` is high on entry L-1, where L is the per-lane length.
- R6: Each entry is written with its own per-lane length L on `inLaneLen`, with L of at least 1. Blocks of different lengths placed back to back are framed correctly, and for L = 1 `outSop` and `outEop` are high on the same entry.
- R7: The full test ignores any read in the same cycle. If the buffer is full and a write arrives together with a read, the read is still carried out, the write is dropped and `overflow` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Write strobe from the engine; it cannot be stalled |
| inSamples | input | LANES*SAMPLE_W | Three IQ samples for one entry, lane-packed |
| inLaneLen | input | LEN_W | Per-lane length of the block this entry belongs to |
| outReady | input | 1 | Downstream ready |
| outValid | output | 1 | At least one entry is stored |
| outSamples | output | LANES*SAMPLE_W | Head entry samples, lane-packed |
| outSop | output | 1 | Head entry is the first entry of its block |
| outEop | output | 1 | Head entry is the last entry of its block |
| overflow | output | 1 | Sticky flag: a write was dropped |

## Verification
The hardest situation to reach is a write and a read landing on the same edge while the buffer is exactly full. Under R7 the read goes ahead and the write is lost. To get there, the bench holds ready low while two whole blocks fill the buffer. It then sends one more block, which must be dropped entirely. Finally it raises ready on the same falling edge as a further write. After draining, the bench checks that only the original entries came out, in order and with correct framing, and that the flag stayed set.

// File: rtl/burst_outbuf_pkg.sv
package burst_outbuf_pkg;

  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic push;  // store the incoming entry at the write pointer
    logic pop;   // retire the head entry
  } bufStrobe_t;

endpackage

// File: rtl/burst_outbuf_data.sv
module burst_outbuf_data
  import burst_outbuf_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int LANES    = 3,
  parameter int DEPTH    = 16,
  parameter int LEN_W    = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  bufStrobe_t                strobe,
  input  logic [LANES*SAMPLE_W-1:0] wrSamples,
  input  logic [LEN_W-1:0]          wrLen,
  output logic [LANES*SAMPLE_W-1:0] headSamples,
  output logic [LEN_W-1:0]          headLen
);
  localparam int DATA_W = LANES * SAMPLE_W;
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2   = ((1 << ADDR_W) == DEPTH);

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] samples;
  } entry_t;

  entry_t              store [DEPTH];
  logic [ADDR_W-1:0]   wrPtr, rdPtr;
  logic [ADDR_W-1:0]   wrNext, rdNext;

  // Pointer wrap: free for power-of-two depths, compared otherwise
  generate
    if (POW2) begin : g_wrapFree
      assign wrNext = wrPtr + ADDR_W'(1);
      assign rdNext = rdPtr + ADDR_W'(1);
    end else begin : g_wrapCmp
      assign wrNext = (wrPtr == ADDR_W'(DEPTH - 1)) ? '0 : wrPtr + ADDR_W'(1);
      assign rdNext = (rdPtr == ADDR_W'(DEPTH - 1)) ? '0 : rdPtr + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrNext;
      if (strobe.pop)  rdPtr <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= '{len: wrLen, samples: wrSamples};
  end

  assign headSamples = store[rdPtr].samples;
  assign headLen     = store[rdPtr].len;

endmodule

// File: rtl/burst_outbuf_ctrl.sv
module burst_outbuf_ctrl
  import burst_outbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [LEN_W-1:0] headLen,
  output bufStrobe_t       strobe,
  output logic             outValid,
  output logic             outSop,
  output logic             outEop,
  output logic             overflow,
  output logic             bufFull
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] fill;
  logic [LEN_W-1:0] pos;   // index of the head entry inside its block

  assign bufFull     = (fill == CNT_W'(DEPTH));
  assign outValid    = (fill != '0);
  assign strobe.push = inValid && !bufFull;
  assign strobe.pop  = outValid && outReady;

  assign outSop = outValid && (pos == '0);
  assign outEop = outValid && (pos == headLen - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill     <= '0;
      pos      <= '0;
      overflow <= 1'b0;
    end else begin
      unique case ({strobe.push, strobe.pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
      if (strobe.pop) pos <= outEop ? '0 : pos + LEN_W'(1);
      if (inValid && bufFull) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/burst_outbuf.sv
module burst_outbuf
  import burst_outbuf_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int LANES    = 3,
  parameter int DEPTH    = 16,
  parameter int LEN_W    = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  input  logic [LANES*SAMPLE_W-1:0] inSamples,
  input  logic [LEN_W-1:0]          inLaneLen,
  input  logic                      outReady,
  output logic                      outValid,
  output logic [LANES*SAMPLE_W-1:0] outSamples,
  output logic                      outSop,
  output logic                      outEop,
  output logic                      overflow
);
  bufStrobe_t       strobe;
  logic [LEN_W-1:0] headLen;
  logic             bufFull;

  burst_outbuf_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .outReady(outReady),
    .headLen(headLen), .strobe(strobe), .outValid(outValid),
    .outSop(outSop), .outEop(outEop), .overflow(overflow), .bufFull(bufFull)
  );

  burst_outbuf_data #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .DEPTH(DEPTH),
                      .LEN_W(LEN_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrSamples(inSamples),
    .wrLen(inLaneLen), .headSamples(outSamples), .headLen(headLen)
  );

endmodule

// File: rtl/burst_outbuf_chk.sv
module burst_outbuf_chk #(
  parameter int DATA_W = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              bufFull,
  input logic              outReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outSamples,
  input logic              outSop,
  input logic              outEop,
  input logic              overflow
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!outValid && !overflow));

  // R2
  a_r2_write_shows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !bufFull |=> outValid);
  a_r2_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid && !inValid |=> !outValid);

  // R3
  a_r3_flag_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && bufFull |=> overflow);
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R4
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outSamples)
                              && $stable(outSop) && $stable(outEop));

  // R5
  a_r5_sop_follows_eop: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && outReady && outEop |=> !outValid || outSop);
  a_r5_marks_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (outSop || outEop) |-> outValid);

endmodule

bind burst_outbuf burst_outbuf_chk #(.DATA_W(LANES*SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .bufFull(bufFull),
  .outReady(outReady), .outValid(outValid), .outSamples(outSamples),
  .outSop(outSop), .outEop(outEop), .overflow(overflow)
);

// File: tb/burst_outbuf_bench.sv
module burst_outbuf_bench;
  localparam int SW = 8, LANES = 3, DEPTH = 8, LW = 6;
  localparam int DW = LANES * SW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic [DW-1:0] inSamples = '0;
  logic [LW-1:0] inLaneLen = '0;
  logic          outValid, outSop, outEop, overflow;
  logic [DW-1:0] outSamples;

  burst_outbuf #(.SAMPLE_W(SW), .LANES(LANES), .DEPTH(DEPTH), .LEN_W(LW))
    u_burst_outbuf (.*);

  int checks = 0, fails = 0, held = 0;
  logic [DW+1:0] q[$];   // {samples, sop, eop}

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(int tag, int idx);
    logic [DW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*SW +: SW] = SW'(tag * 40 + idx * 3 + k);
    return v;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; inValid = 0; outReady = 0; held = 0;
    q.delete();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "valid in reset", outValid, 0);
    check("R1", "overflow in reset", overflow, 0);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1", "valid after reset", outValid, 0);
    check("R1", "sop/eop after reset", {outSop, outEop}, 0);
  endtask

  // writes with outReady low; model stores only what fits
  task automatic writeBlock(int len, int tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1; inSamples = mk(tag, i); inLaneLen = LW'(len);
      if (held < DEPTH) begin
        q.push_back({mk(tag, i), i == 0, i == len - 1});
        held++;
      end
    end
    @(negedge clk); inValid = 0;
  endtask

  task automatic compareHead(string req);
    check(req, "valid", outValid, 1);
    check(req, "samples", outSamples, q[0][DW+1:2]);
    check(req, "sop", outSop, q[0][1]);
    check(req, "eop", outEop, q[0][0]);
  endtask

  // pattern 0: ready always, 1: every other cycle, 2: one cycle in three
  task automatic drain(int pattern, string req);
    int cyc = 0;
    while (q.size() > 0 && cyc < 200) begin
      @(negedge clk);
      outReady = (pattern == 0) || (pattern == 1 && cyc % 2 == 1) ||
                 (pattern == 2 && cyc % 3 == 2);
      #1;
      compareHead(req);
      if (outReady) begin
        void'(q.pop_front());
        held--;
      end
      cyc++;
    end
    @(negedge clk); outReady = 0;
    #1;
    check(req, "empty after drain", outValid, 0);
  endtask

  task automatic testFwft();
    @(negedge clk);
    inValid = 1; inSamples = mk(1, 0); inLaneLen = LW'(1);
    #1;
    check("R2", "valid before edge", outValid, 0);
    @(negedge clk); inValid = 0;
    q.push_back({mk(1, 0), 1'b1, 1'b1}); held++;
    #1;
    compareHead("R2");
    drain(0, "R2");
  endtask

  task automatic testSingleBlock();
    writeBlock(4, 2);
    drain(0, "R5");
  endtask

  task automatic testBackpressure();
    writeBlock(3, 3);
    writeBlock(3, 4);
    drain(1, "R4");
  endtask

  task automatic testMixedLengths();
    writeBlock(3, 5);
    writeBlock(1, 6);
    writeBlock(2, 7);
    drain(2, "R6");
  endtask

  task automatic testOverflow();
    doReset();
    writeBlock(4, 8);
    writeBlock(4, 9);
    #1;
    check("R3", "no flag at exactly full", overflow, 0);
    writeBlock(2, 10);          // dropped entirely
    #1;
    check("R3", "flag after dropped write", overflow, 1);
    compareHead("R3");
    // full: write and read together
    @(negedge clk);
    outReady = 1; inValid = 1; inSamples = mk(11, 0); inLaneLen = LW'(1);
    #1;
    compareHead("R7");
    void'(q.pop_front()); held--;
    @(negedge clk); outReady = 0; inValid = 0;
    #1;
    compareHead("R7");
    drain(0, "R7");
    check("R3", "flag sticky", overflow, 1);
    doReset();
    check("R3", "flag cleared by reset", overflow, 0);
  endtask

  initial begin
    doReset();
    testFwft();
    testSingleBlock();
    testBackpressure();
    testMixedLengths();
    testOverflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule